// File: doc/BRIEF.md
# Divergent Index Waterfall Sequencer

This block turns one register-indexed move, in which each of `LANES` lanes may carry its own `IDXW`-bit index, into a series of moves. Within each move every selected lane uses the same index. A start pulse latches the active lane mask. The sequencer then runs one pass per distinct index value. Each pass takes the index held by the lowest-numbered lane still pending. It selects every pending lane that holds the same index and issues a one-cycle move strobe carrying that index and lane subset. Those lanes then leave the pending set. When no lanes are pending, the latched mask is driven back on the execution mask output and `done` pulses.

When the caller flags the index as already uniform, the loop is skipped. A single move carries the scalar index and the full latched mask. The register file and the move datapath are outside the block. They see only the strobe ports. The per-lane index vector and the scalar index must be held stable while `busy` is high. The active mask is read only in the cycle a start is accepted.

Top module: `idx_wf_top`

## Requirements
- R1: After reset, `busy`, `done` and `moveFire` are 0 and `execMask` is all zeros.
- R2: A `startReq` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the cycle `done` is 1. A `startReq` while `busy` is 1 has no effect on the moves issued or on the mask restored.
- R3: On each pass, `moveIdx` equals the index of the lowest-numbered lane still pending. Lane i's index occupies bits `[i*IDXW +: IDXW]` of `laneIdx`.
- R4: On each pass, `moveLanes` (bit i = lane i) holds exactly the pending lanes whose index equals `moveIdx`. During that cycle, `execMask` equals `moveLanes`.
- R5: Passes follow on consecutive cycles, and the first is one cycle after acceptance. Each pass removes its lanes from the pending set. The number of passes equals the number of distinct index values among the active lanes.
- R6: `done` is a one-cycle pulse one cycle after the last move. `busy` falls in that same cycle.
- R7: While `done` is 1, `execMask` equals the active mask latched at acceptance, and it holds that value afterwards until the next move.
- R8: With `idxUniform` = 1 and a nonzero mask, exactly one move is issued one cycle after acceptance, with `moveIdx` = `scalarIdx` and `moveLanes` = the latched mask. `done` follows one cycle later.
- R9: A start with an all-zero active mask issues no move, in either mode. `done` pulses one cycle after acceptance.
- R10: Lanes outside the latched mask never appear in `moveLanes`, even when their index equals the current pass index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse |
| idxUniform | input | 1 | 1 = index is scalar, bypass the loop |
| activeMask | input | LANES | Lanes active at start |
| laneIdx | input | LANES*IDXW | Per-lane indices, lane i at [i*IDXW +: IDXW] |
| scalarIdx | input | IDXW | Index used in uniform mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| moveFire | output | 1 | Move strobe, one cycle per pass |
| moveIdx | output | IDXW | Uniform index for the current move |
| moveLanes | output | LANES | Lane subset for the current move |
| execMask | output | LANES | Execution mask: subset per pass, restored mask at done |

## Verification
A start sampled at clock edge 0 gives `busy` after that edge and the k-th move after edge k. `done` and the restored mask follow after edge N+1, where N is the pass count. An all-zero mask gives N = 0, and uniform mode gives N = 1. For each operation the driver computes N from its own model of the lane indices and samples every cycle from 0 through N+1 on the falling edge, checking `busy`, `moveFire` and `done` against that count. A scoreboard queue holds the expected index and lane subset of each pass, and the monitor compares each strobe with it in order.

// File: rtl/idx_wf_pkg.sv
package idx_wf_pkg;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic capture;   // latch active mask into saved and pending
    logic passStep;  // issue one divergent pass
    logic uniStep;   // issue the single uniform move
    logic finish;    // restore the saved mask
  } wfStrobes_t;

  typedef enum logic [1:0] {
    WF_IDLE = 2'd0,
    WF_PASS = 2'd1,
    WF_UNI  = 2'd2,
    WF_FIN  = 2'd3
  } wfState_e;

endpackage

// File: rtl/idx_wf_lead.sv
// Lowest-numbered set bit finder over the pending lane mask.
module idx_wf_lead #(
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pendMask,
  output logic [LW-1:0]    leadLane,
  output logic             leadValid
);

  always_comb begin
    leadLane  = '0;
    leadValid = |pendMask;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendMask[i]) leadLane = LW'(i);
    end
  end

endmodule

// File: rtl/idx_wf_ctrl.sv
module idx_wf_ctrl
  import idx_wf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       idxUniform,
  input  logic       maskZero,
  input  logic       lastPass,
  output wfStrobes_t strb,
  output logic       busy,
  output logic       done
);

  wfState_e state;

  always_comb begin
    strb.capture  = (state == WF_IDLE) && startReq;
    strb.passStep = (state == WF_PASS);
    strb.uniStep  = (state == WF_UNI);
    strb.finish   = (state == WF_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= WF_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        WF_IDLE: begin
          if (startReq) begin
            busy <= 1'b1;
            if (maskZero)        state <= WF_FIN;
            else if (idxUniform) state <= WF_UNI;
            else                 state <= WF_PASS;
          end
        end
        WF_PASS: begin
          if (lastPass) state <= WF_FIN;
        end
        WF_UNI: state <= WF_FIN;
        WF_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= WF_IDLE;
        end
        default: state <= WF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idx_wf_datapath.sv
module idx_wf_datapath
  import idx_wf_pkg::*;
#(
  parameter int LANES = 64,
  parameter int IDXW  = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wfStrobes_t            strb,
  input  logic [LANES-1:0]      activeMask,
  input  logic [LANES*IDXW-1:0] laneIdx,
  input  logic [IDXW-1:0]       scalarIdx,
  output logic                  maskZero,
  output logic                  lastPass,
  output logic                  moveFire,
  output logic [IDXW-1:0]       moveIdx,
  output logic [LANES-1:0]      moveLanes,
  output logic [LANES-1:0]      execMask
);

  logic [LANES-1:0] pendMask;
  logic [LANES-1:0] savedMask;
  logic [LANES-1:0] matchVec;
  logic [LW-1:0]    leadLane;
  logic             leadValid;
  logic [IDXW-1:0]  leadIdx;

  idx_wf_lead #(.LANES(LANES)) u_lead (
    .pendMask (pendMask),
    .leadLane (leadLane),
    .leadValid(leadValid)
  );

  always_comb begin
    leadIdx = laneIdx[int'(leadLane)*IDXW +: IDXW];
  end

  // one comparator per lane against the broadcast leader index
  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign matchVec[g] = pendMask[g] && (laneIdx[g*IDXW +: IDXW] == leadIdx);
  end

  assign maskZero = ~|activeMask;
  assign lastPass = ((pendMask ^ matchVec) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask  <= '0;
      savedMask <= '0;
      moveFire  <= 1'b0;
      moveIdx   <= '0;
      moveLanes <= '0;
      execMask  <= '0;
    end else begin
      moveFire <= 1'b0;
      if (strb.capture) begin
        savedMask <= activeMask;
        pendMask  <= activeMask;
      end
      if (strb.passStep && leadValid) begin
        moveFire  <= 1'b1;
        moveIdx   <= leadIdx;
        moveLanes <= matchVec;
        execMask  <= matchVec;
        pendMask  <= pendMask ^ matchVec;
      end
      if (strb.uniStep) begin
        moveFire  <= 1'b1;
        moveIdx   <= scalarIdx;
        moveLanes <= savedMask;
        execMask  <= savedMask;
        pendMask  <= '0;
      end
      if (strb.finish) begin
        execMask <= savedMask;
      end
    end
  end

endmodule

// File: rtl/idx_wf_top.sv
module idx_wf_top
  import idx_wf_pkg::*;
#(
  parameter int LANES = 64,
  parameter int IDXW  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  idxUniform,
  input  logic [LANES-1:0]      activeMask,
  input  logic [LANES*IDXW-1:0] laneIdx,
  input  logic [IDXW-1:0]       scalarIdx,
  output logic                  busy,
  output logic                  done,
  output logic                  moveFire,
  output logic [IDXW-1:0]       moveIdx,
  output logic [LANES-1:0]      moveLanes,
  output logic [LANES-1:0]      execMask
);

  wfStrobes_t strb;
  logic       maskZero;
  logic       lastPass;

  idx_wf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .idxUniform(idxUniform),
    .maskZero  (maskZero),
    .lastPass  (lastPass),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  idx_wf_datapath #(.LANES(LANES), .IDXW(IDXW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .activeMask(activeMask),
    .laneIdx   (laneIdx),
    .scalarIdx (scalarIdx),
    .maskZero  (maskZero),
    .lastPass  (lastPass),
    .moveFire  (moveFire),
    .moveIdx   (moveIdx),
    .moveLanes (moveLanes),
    .execMask  (execMask)
  );

endmodule

// File: rtl/idx_wf_chk.sv
module idx_wf_chk #(
  parameter int LANES = 64,
  parameter int IDXW  = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startReq,
  input logic                  idxUniform,
  input logic [LANES-1:0]      activeMask,
  input logic [LANES*IDXW-1:0] laneIdx,
  input logic                  busy,
  input logic                  done,
  input logic                  moveFire,
  input logic [IDXW-1:0]       moveIdx,
  input logic [LANES-1:0]      moveLanes,
  input logic [LANES-1:0]      execMask
);

  logic [LANES-1:0] capMask;
  logic             capUni;
  logic [LANES-1:0] covered;
  logic [LANES-1:0] eqVec;
  logic [LANES-1:0] leftMask;
  logic [IDXW-1:0]  firstLeftIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capMask <= '0;
      capUni  <= 1'b0;
      covered <= '0;
    end else if (startReq && !busy) begin
      capMask <= activeMask;
      capUni  <= idxUniform;
      covered <= '0;
    end else if (moveFire) begin
      covered <= covered | moveLanes;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_eq
    assign eqVec[g] = (laneIdx[g*IDXW +: IDXW] == moveIdx);
  end

  assign leftMask = capMask & ~covered;

  always_comb begin
    firstLeftIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (leftMask[i]) firstLeftIdx = laneIdx[i*IDXW +: IDXW];
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R2
  move_busy_chk: assert property (@(posedge clk) disable iff (!rstN) moveFire |-> busy);
  // R10
  move_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveFire |-> ((moveLanes & ~capMask) == '0));
  // R5
  move_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveFire |-> ((moveLanes & covered) == '0));
  // R5
  cover_all_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (covered == capMask));
  // R7
  restore_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (execMask == capMask));
  // R4
  move_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (moveFire && !capUni) |-> ((moveLanes & ~eqVec) == '0));
  // R4
  exec_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveFire |-> (execMask == moveLanes));
  // R9
  move_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveFire |-> (moveLanes != '0));
  // R3
  leader_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (moveFire && !capUni) |-> (moveIdx == firstLeftIdx));

endmodule

bind idx_wf_top idx_wf_chk #(.LANES(LANES), .IDXW(IDXW)) u_chk (.*);

// File: tb/idx_wf_top_tb.sv
module idx_wf_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int IDXW  = 32;

  typedef struct packed {
    logic [IDXW-1:0]  idx;
    logic [LANES-1:0] lanes;
  } expMove_t;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  startReq = 1'b0;
  logic                  idxUniform = 1'b0;
  logic [LANES-1:0]      activeMask = '0;
  logic [LANES*IDXW-1:0] laneIdx;
  logic [IDXW-1:0]       scalarIdx = '0;
  logic                  busy, done, moveFire;
  logic [IDXW-1:0]       moveIdx;
  logic [LANES-1:0]      moveLanes, execMask;

  logic [IDXW-1:0] lidx [LANES];
  expMove_t expQ[$];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < LANES; i++) laneIdx[i*IDXW +: IDXW] = lidx[i];
  end

  idx_wf_top #(.LANES(LANES), .IDXW(IDXW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compare each move strobe with the scoreboard head
  always @(negedge clk) begin
    if (rstN) begin
      if (moveFire) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", "unexpected move", 64'(moveLanes), 64'(0));
        end else begin
          expMove_t e;
          e = expQ.pop_front();
          chk(moveIdx == e.idx, "R3", "move index", 64'(moveIdx), 64'(e.idx));
          chk(moveLanes == e.lanes, "R4", "move lanes", moveLanes, e.lanes);
          chk(execMask == e.lanes, "R4", "exec mask in pass", execMask, e.lanes);
        end
      end
      if (done) chk(expQ.size() == 0, "R5", "moves left at done", 64'(expQ.size()), 64'(0));
    end
  end

  // driver: model the expected passes, push them, then check timing cycle by cycle
  task automatic runOp(input logic [LANES-1:0] mask, input bit uni,
                       input logic [IDXW-1:0] sidx, input bit junk, input string tag);
    int n = 0;
    logic [LANES-1:0] pend = mask;
    if (mask != '0 && uni) begin
      expQ.push_back('{idx: sidx, lanes: mask});
      n = 1;
    end else begin
      while (pend != '0) begin
        int lead = 0;
        logic [LANES-1:0] m = '0;
        for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
        for (int i = 0; i < LANES; i++) if (pend[i] && lidx[i] == lidx[lead]) m[i] = 1'b1;
        expQ.push_back('{idx: lidx[lead], lanes: m});
        pend = pend ^ m;
        n++;
      end
    end
    @(negedge clk);
    activeMask = mask; idxUniform = uni; scalarIdx = sidx; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy == 1'b1, "R2", {tag, " busy after start"}, 64'(busy), 64'(1));
    chk(moveFire == 1'b0, "R5", {tag, " no move at accept"}, 64'(moveFire), 64'(0));
    for (int c = 1; c <= n + 1; c++) begin
      @(negedge clk);
      chk(busy == (c <= n), "R2", {tag, " busy"}, 64'(busy), 64'(c <= n));
      chk(moveFire == (c <= n), tag, "move strobe timing", 64'(moveFire), 64'(c <= n));
      chk(done == (c == n + 1), "R6", {tag, " done timing"}, 64'(done), 64'(c == n + 1));
      if (c == n + 1) chk(execMask == mask, "R7", {tag, " restored mask"}, execMask, mask);
      if (junk) begin
        if (c == 1) begin startReq = 1'b1; activeMask = ~mask; end
        else begin startReq = 1'b0; activeMask = mask; end
      end
    end
    startReq = 1'b0;
    activeMask = mask;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6", {tag, " idle after done"}, 64'({busy, done}), 64'(0));
    chk(execMask == mask, "R7", {tag, " mask held"}, execMask, mask);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < LANES; i++) lidx[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && moveFire == 0, "R1", "reset strobes",
        64'({busy, done, moveFire}), 64'(0));
    chk(execMask == '0, "R1", "reset exec mask", execMask, 64'(0));
    rstN = 1'b1;

    // all lanes same index, one pass
    for (int i = 0; i < LANES; i++) lidx[i] = 32'hCAFE_0007;
    runOp('1, 1'b0, '0, 1'b0, "R5");

    // four index groups interleaved
    for (int i = 0; i < LANES; i++) lidx[i] = 32'(i % 4) + 32'h100;
    runOp('1, 1'b0, '0, 1'b0, "R3");

    // sparse mask; inactive lanes share the leader value (R10)
    for (int i = 0; i < LANES; i++) lidx[i] = 32'(i % 3);
    runOp(64'h0000_F000_0000_0F0A, 1'b0, '0, 1'b0, "R10");

    // every lane distinct: 64 passes
    for (int i = 0; i < LANES; i++) lidx[i] = 32'hFFFF_FF00 - 32'(i * 7);
    runOp('1, 1'b0, '0, 1'b0, "R5");

    // single top lane
    runOp(64'h8000_0000_0000_0000, 1'b0, '0, 1'b0, "R3");

    // uniform bypass
    runOp(64'h00FF_0000_1234_5678, 1'b1, 32'h0000_ABCD, 1'b0, "R8");

    // zero mask in both modes
    runOp('0, 1'b0, '0, 1'b0, "R9");
    runOp('0, 1'b1, 32'h55, 1'b0, "R9");

    // start while busy is ignored
    for (int i = 0; i < LANES; i++) lidx[i] = 32'(i % 5);
    runOp(64'h0F0F_0F0F_3333_0001, 1'b0, '0, 1'b1, "R2");

    // pairs of equal indices scattered far apart
    for (int i = 0; i < LANES; i++) lidx[i] = 32'((i * 13) % 8);
    runOp(64'hA5A5_5A5A_C3C3_3C3C, 1'b0, '0, 1'b0, "R4");

    summary();
  end

endmodule